// File: doc/BRIEF.md
# Dual-Clock Show-Ahead FIFO With Ready Flags

This block is an 18-bit, 1024-word FIFO that links two unrelated, free-running clock domains. The producer writes on its own clock while an input-ready flag is high. The consumer sees words on its own clock through a show-ahead output register. The first stored word appears on the output without any read request. Each later word is taken on a read-clock edge where both read enables, the output enable and output-ready are high.

Pointers cross between domains as Gray codes through two-flop synchronisers. Each domain samples the active-low reset through its own two-flop chain. This fixes the flag latencies as a number of edges of the local clock. Reset must be held for at least four cycles of each clock. The output enable gates the data outputs to zero and also blocks reads.

Top module: `dc_ready_fifo`

## Requirements
- R1: While `rst_ni` is low, `in_rdy_o` goes low on the second write-clock edge and `out_rdy_o` goes low on the third read-clock edge. The FIFO is then empty.
- R2: After `rst_ni` rises, `in_rdy_o` stays low after the first write-clock edge and is high after the second.
- R3: A word is stored only on a write-clock edge where `wr_en_i` and `in_rdy_o` are both high. A write attempt while `in_rdy_o` is low is dropped and never appears at the output.
- R4: After a write into an empty FIFO, `out_rdy_o` stays low after the first and second read-clock edges. After the third edge it is high and `rdata_o` holds that word, with both read enables low.
- R5: A word is consumed only on a read-clock edge where `rd_en_a_i`, `rd_en_b_i`, `oe_i` and `out_rdy_o` are all high. Otherwise the presented word and `out_rdy_o` are held.
- R6: On the read-clock edge that consumes the last stored word, `out_rdy_o` goes low.
- R7: While `oe_i` is low, `rdata_o` is all zeros and no word is consumed.
- R8: Once the first word sits in the output register, the FIFO accepts 1024 more words with no reads (1025 in total). It then holds `in_rdy_o` low.
- R9: After a read from a full FIFO, `in_rdy_o` stays low after the first write-clock edge that follows the read. It is high after the second.
- R10: Words leave in the exact order in which they were accepted, under any interleaving of writes and reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock, free running |
| rclk_i | input | 1 | Read clock, free running |
| rst_ni | input | 1 | Active-low reset, sampled in each domain |
| wr_en_i | input | 1 | Write request |
| wdata_i | input | 18 | Write data |
| in_rdy_o | output | 1 | High when a write will be accepted |
| rd_en_a_i | input | 1 | Read enable, first of two |
| rd_en_b_i | input | 1 | Read enable, second of two |
| oe_i | input | 1 | Output enable; low forces data to zero and blocks reads |
| rdata_o | output | 18 | Presented word |
| out_rdy_o | output | 1 | High when `rdata_o` holds a valid word |

## Verification
A single write into an empty FIFO shows the three-edge fall-through path, separate from any read request. Gating runs hold a word while one of the three read qualifiers is low at a time. These runs show whether each qualifier blocks the pop by itself and whether the output enable also blanks the data. A fill-to-capacity run with writes attempted while full, then a single read and a full drain, checks capacity, dropped writes, recovery latency and the final fall of output-ready together. A random interleaving of writes and reads against a reference queue separates ordering faults from flag-timing faults.

// File: rtl/dcrf_pkg.sv
package dcrf_pkg;
  parameter int unsigned DATA_W_DEF = 18;
  parameter int unsigned ADDR_W_DEF = 10;
  parameter int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/dcrf_rst_sync.sv
module dcrf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic lrst_no
);
  logic [STAGES-1:0] chain_q;
  // reset level sampled, not forced, so flag latencies count local edges
  always_ff @(posedge clk_i) chain_q <= {chain_q[STAGES-2:0], rst_ni};
  assign lrst_no = chain_q[STAGES-1];
endmodule

// File: rtl/dcrf_sync.sv
module dcrf_sync #(
  parameter int unsigned W      = 11,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         lrst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i) begin
      if (!lrst_ni) st_q[s] <= '0;
      else if (s == 0) st_q[s] <= d_i;
      else st_q[s] <= st_q[(s == 0) ? 0 : s-1];
    end
  end
  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/dcrf_mem.sv
module dcrf_mem #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem_q [DEPTH];
  always_ff @(posedge wclk_i) if (we_i) mem_q[waddr_i] <= wdata_i;
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dcrf_wr_ctrl.sv
module dcrf_wr_ctrl #(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              lrst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W:0]   rgray_sync_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [ADDR_W:0]   wgray_o,
  output logic              in_rdy_o
);
  localparam int unsigned PTR_W = ADDR_W + 1;
  logic [PTR_W-1:0] wbin_q, wbin_nx, wgray_q;
  logic full;

  // full: pointers equal except the two top Gray bits inverted
  assign full     = (wgray_q == {~rgray_sync_i[PTR_W-1:PTR_W-2], rgray_sync_i[PTR_W-3:0]});
  assign in_rdy_o = lrst_ni & ~full;
  assign we_o     = wr_en_i & in_rdy_o;
  assign wbin_nx  = wbin_q + PTR_W'(1);

  always_ff @(posedge clk_i) begin
    if (!lrst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (we_o) begin
      wbin_q  <= wbin_nx;
      wgray_q <= wbin_nx ^ (wbin_nx >> 1);
    end
  end

  assign waddr_o = wbin_q[ADDR_W-1:0];
  assign wgray_o = wgray_q;
endmodule

// File: rtl/dcrf_rd_ctrl.sv
module dcrf_rd_ctrl #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              lrst_ni,
  input  logic              rd_en_a_i,
  input  logic              rd_en_b_i,
  input  logic              oe_i,
  input  logic [ADDR_W:0]   wgray_sync_i,
  input  logic [DATA_W-1:0] mem_q_i,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [ADDR_W:0]   rgray_o,
  output logic [DATA_W-1:0] dout_o,
  output logic              out_rdy_o
);
  localparam int unsigned PTR_W = ADDR_W + 1;
  logic [PTR_W-1:0] rbin_q, rbin_nx, rgray_q;
  logic [DATA_W-1:0] dout_q;
  logic vld_q, fire, empty, load;

  assign fire    = rd_en_a_i & rd_en_b_i & oe_i & vld_q;
  assign empty   = (rgray_q == wgray_sync_i);
  // show-ahead: refill the output register when it is free or being popped
  assign load    = ~empty & (~vld_q | fire);
  assign rbin_nx = rbin_q + PTR_W'(1);

  always_ff @(posedge clk_i) begin
    if (!lrst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      vld_q   <= 1'b0;
    end else if (load) begin
      rbin_q  <= rbin_nx;
      rgray_q <= rbin_nx ^ (rbin_nx >> 1);
      vld_q   <= 1'b1;
    end else if (fire) begin
      vld_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) if (lrst_ni && load) dout_q <= mem_q_i;

  assign raddr_o   = rbin_q[ADDR_W-1:0];
  assign rgray_o   = rgray_q;
  assign dout_o    = dout_q;
  assign out_rdy_o = vld_q;
endmodule

// File: rtl/dc_ready_fifo.sv
module dc_ready_fifo #(
  parameter int unsigned DATA_W = dcrf_pkg::DATA_W_DEF,
  parameter int unsigned ADDR_W = dcrf_pkg::ADDR_W_DEF
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              in_rdy_o,
  input  logic              rd_en_a_i,
  input  logic              rd_en_b_i,
  input  logic              oe_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              out_rdy_o
);
  localparam int unsigned PTR_W = ADDR_W + 1;
  localparam int unsigned SYNC  = dcrf_pkg::SYNC_STAGES;

  logic w_lrst_n, r_lrst_n, we;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PTR_W-1:0]  wgray, rgray, rgray_w, wgray_r;
  logic [DATA_W-1:0] mem_q, dout;

  dcrf_rst_sync #(.STAGES(SYNC)) u_wrst (.clk_i(wclk_i), .rst_ni(rst_ni), .lrst_no(w_lrst_n));
  dcrf_rst_sync #(.STAGES(SYNC)) u_rrst (.clk_i(rclk_i), .rst_ni(rst_ni), .lrst_no(r_lrst_n));

  dcrf_sync #(.W(PTR_W), .STAGES(SYNC)) u_r2w (
    .clk_i(wclk_i), .lrst_ni(w_lrst_n), .d_i(rgray), .q_o(rgray_w));
  dcrf_sync #(.W(PTR_W), .STAGES(SYNC)) u_w2r (
    .clk_i(rclk_i), .lrst_ni(r_lrst_n), .d_i(wgray), .q_o(wgray_r));

  dcrf_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
    .clk_i(wclk_i), .lrst_ni(w_lrst_n), .wr_en_i(wr_en_i), .rgray_sync_i(rgray_w),
    .we_o(we), .waddr_o(waddr), .wgray_o(wgray), .in_rdy_o(in_rdy_o));

  dcrf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wclk_i(wclk_i), .we_i(we), .waddr_i(waddr), .wdata_i(wdata_i),
    .raddr_i(raddr), .rdata_o(mem_q));

  dcrf_rd_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk_i(rclk_i), .lrst_ni(r_lrst_n), .rd_en_a_i(rd_en_a_i), .rd_en_b_i(rd_en_b_i),
    .oe_i(oe_i), .wgray_sync_i(wgray_r), .mem_q_i(mem_q), .raddr_o(raddr),
    .rgray_o(rgray), .dout_o(dout), .out_rdy_o(out_rdy_o));

  assign rdata_o = oe_i ? dout : '0;
endmodule

// File: rtl/dcrf_chk.sv
module dcrf_chk #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned ADDR_W = 10
) (
  input logic              wclk_i,
  input logic              rclk_i,
  input logic              rst_ni,
  input logic              in_rdy_i,
  input logic              out_rdy_i,
  input logic              rd_en_a_i,
  input logic              rd_en_b_i,
  input logic              oe_i,
  input logic [ADDR_W:0]   wgray_i,
  input logic [ADDR_W:0]   rgray_i,
  input logic [ADDR_W:0]   rgray_w_i,
  input logic [DATA_W-1:0] dout_i
);
  localparam int unsigned PTR_W = ADDR_W + 1;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  function automatic logic [PTR_W-1:0] g2b(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PTR_W-1:0] occ_w;
  assign occ_w = g2b(wgray_i) - g2b(rgray_w_i);

  assert_full_blocks_write_R3: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !in_rdy_i |=> $stable(wgray_i));

  assert_depth_bound_R8: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    occ_w <= PTR_W'(DEPTH));

  assert_hold_word_R5: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (out_rdy_i && !(rd_en_a_i && rd_en_b_i && oe_i)) |=> (out_rdy_i && $stable(dout_i)));

  assert_drop_on_read_R6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $fell(out_rdy_i) |-> $past(rd_en_a_i && rd_en_b_i && oe_i));

  assert_wgray_step_R10: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $countones(wgray_i ^ $past(wgray_i)) <= 1);

  assert_rgray_step_R10: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $countones(rgray_i ^ $past(rgray_i)) <= 1);
endmodule

bind dc_ready_fifo dcrf_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni), .in_rdy_i(in_rdy_o),
  .out_rdy_i(out_rdy_o), .rd_en_a_i(rd_en_a_i), .rd_en_b_i(rd_en_b_i), .oe_i(oe_i),
  .wgray_i(wgray), .rgray_i(rgray), .rgray_w_i(rgray_w), .dout_i(dout));

// File: tb/dc_ready_fifo_test.sv
module dc_ready_fifo_test;
  localparam int DW = 18;
  localparam int DEPTH = 1024;

  logic wclk = 0, rclk = 0, rst_ni = 0;
  logic wr_en = 0, rd_a = 0, rd_b = 0, oe = 1;
  logic [DW-1:0] wdata = '0, rdata;
  logic in_rdy, out_rdy;
  int total = 0, fail = 0;

  dc_ready_fifo uut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wdata_i(wdata),
    .in_rdy_o(in_rdy), .rd_en_a_i(rd_a), .rd_en_b_i(rd_b), .oe_i(oe),
    .rdata_o(rdata), .out_rdy_o(out_rdy));

  always #5 wclk = ~wclk;
  initial begin #3; forever #5 rclk = ~rclk; end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_word(input logic [DW-1:0] d);
    @(posedge wclk); #1; wr_en = 1; wdata = d;
    @(posedge wclk); #1; wr_en = 0;
  endtask

  // R2: release and count write edges
  task automatic t_release;
    repeat (6) @(posedge wclk);
    #1 rst_ni = 1;
    @(posedge wclk); #1 check(in_rdy == 0, "R2", "in_rdy after edge 1", in_rdy, 0);
    @(posedge wclk); #1 check(in_rdy == 1, "R2", "in_rdy after edge 2", in_rdy, 1);
    repeat (4) @(posedge rclk);
    #1 check(out_rdy == 0, "R1", "out_rdy empty after reset", out_rdy, 0);
  endtask

  // R4: first word falls through on third read edge
  task automatic t_first_word;
    @(posedge wclk); #1; wr_en = 1; wdata = 18'h2A5C3;
    @(posedge wclk); #1; wr_en = 0;
    @(posedge rclk); #1 check(out_rdy == 0, "R4", "out_rdy edge 1", out_rdy, 0);
    @(posedge rclk); #1 check(out_rdy == 0, "R4", "out_rdy edge 2", out_rdy, 0);
    @(posedge rclk); #1 check(out_rdy == 1, "R4", "out_rdy edge 3", out_rdy, 1);
    check(rdata == 18'h2A5C3, "R4", "first word", rdata, 18'h2A5C3);
  endtask

  // R1: flags drop on fixed edges while reset is low
  task automatic t_reset_assert;
    @(posedge wclk); #1 rst_ni = 0;
    fork
      begin
        @(posedge wclk); #1 check(in_rdy == 1, "R1", "in_rdy edge 1", in_rdy, 1);
        @(posedge wclk); #1 check(in_rdy == 0, "R1", "in_rdy edge 2", in_rdy, 0);
      end
      begin
        @(posedge rclk); #1 check(out_rdy == 1, "R1", "out_rdy edge 1", out_rdy, 1);
        @(posedge rclk); #1 check(out_rdy == 1, "R1", "out_rdy edge 2", out_rdy, 1);
        @(posedge rclk); #1 check(out_rdy == 0, "R1", "out_rdy edge 3", out_rdy, 0);
      end
    join
    t_release;
  endtask

  // R5, R7, R6: qualifiers block pops one at a time
  task automatic t_gating;
    wr_word(18'h00111);
    wr_word(18'h00222);
    repeat (6) @(posedge rclk);
    #1 check(rdata == 18'h00111 && out_rdy, "R5", "head word", rdata, 18'h00111);
    rd_a = 1; rd_b = 0; oe = 1;
    @(posedge rclk); #1 check(rdata == 18'h00111, "R5", "rd_en_b low holds", rdata, 18'h00111);
    rd_a = 0; rd_b = 1;
    @(posedge rclk); #1 check(rdata == 18'h00111, "R5", "rd_en_a low holds", rdata, 18'h00111);
    rd_a = 1; oe = 0;
    #1 check(rdata == 0, "R7", "oe low blanks data", rdata, 0);
    @(posedge rclk); #1 check(out_rdy == 1, "R7", "oe low keeps word", out_rdy, 1);
    rd_a = 0; rd_b = 0; oe = 1;
    #1 check(rdata == 18'h00111, "R7", "no pop while oe low", rdata, 18'h00111);
    rd_a = 1; rd_b = 1;
    @(posedge rclk); #1 check(rdata == 18'h00222 && out_rdy, "R5", "pop shows next", rdata, 18'h00222);
    @(posedge rclk); #1 check(out_rdy == 0, "R6", "out_rdy after last pop", out_rdy, 0);
    rd_a = 0; rd_b = 0;
  endtask

  // R8, R3, R9, R6, R10: fill, dropped writes, recovery, drain
  task automatic t_fill_drain;
    int n = 0;
    wr_word(18'h10000);
    n = 1;
    repeat (8) @(posedge rclk);
    @(posedge wclk); #1;
    while (in_rdy && n < DEPTH + 10) begin
      wr_en = 1; wdata = DW'(18'h10000 + n);
      @(posedge wclk); #1; n++;
    end
    wr_en = 0;
    check(n == DEPTH + 1, "R8", "accepted words", n, DEPTH + 1);
    wr_en = 1; wdata = 18'h3FFFF;
    repeat (5) begin
      @(posedge wclk); #1 check(in_rdy == 0, "R3", "full stays closed", in_rdy, 0);
    end
    wr_en = 0;
    repeat (6) @(posedge wclk);
    #1 check(in_rdy == 0, "R8", "in_rdy low when full", in_rdy, 0);
    @(posedge rclk); #1; rd_a = 1; rd_b = 1; oe = 1;
    @(posedge rclk); #1; rd_a = 0; rd_b = 0;
    @(posedge wclk); #1 check(in_rdy == 0, "R9", "in_rdy wclk edge 1", in_rdy, 0);
    @(posedge wclk); #1 check(in_rdy == 1, "R9", "in_rdy wclk edge 2", in_rdy, 1);
    @(posedge rclk); #1; rd_a = 1; rd_b = 1;
    for (int i = 1; i < DEPTH + 1; i++) begin
      if (rdata != DW'(18'h10000 + i) || !out_rdy)
        check(0, "R10", "drain order", rdata, 18'h10000 + i);
      @(posedge rclk); #1;
    end
    check(1, "R10", "drain order", 0, 0);
    check(out_rdy == 0, "R6", "empty after drain", out_rdy, 0);
    check(rdata != 18'h3FFFF, "R3", "dropped word absent", rdata, 0);
    rd_a = 0; rd_b = 0;
  endtask

  // R10: random interleaving against a reference queue
  task automatic t_stream;
    logic [DW-1:0] q[$];
    int sent = 0, got = 0, bad = 0;
    fork
      while (sent < 60) begin
        @(negedge wclk);
        wr_en = ($urandom_range(0, 3) != 0); wdata = DW'($urandom);
        #4 if (wr_en && in_rdy) begin q.push_back(wdata); sent++; end
      end
      while (got < 60) begin
        @(negedge rclk);
        rd_a = ($urandom_range(0, 2) != 0); rd_b = ($urandom_range(0, 3) != 0); oe = 1;
        #4 if (rd_a && rd_b && out_rdy) begin
          if (q.size() == 0 || rdata != q[0]) begin
            bad++;
            check(0, "R10", "stream word", rdata, (q.size() != 0) ? q[0] : 0);
          end
          if (q.size() != 0) void'(q.pop_front());
          got++;
        end
      end
    join
    @(negedge wclk); wr_en = 0;
    @(negedge rclk); rd_a = 0; rd_b = 0;
    check(bad == 0 && q.size() == 0, "R10", "stream complete", q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    fail++; total++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fail, total);
    $finish;
  end

  initial begin
    t_release;
    t_first_word;
    t_reset_assert;
    t_gating;
    t_fill_drain;
    t_stream;
    $display("%0d/%0d checks passed", total - fail, total);
    $finish;
  end
endmodule